// File: doc/BRIEF.md
# Not-Recently-Used Class Victim Selector

This block chooses which way of one cache set should be evicted next. For every way it keeps two state bits. One is a referenced flag and the other is a modified flag. Each way falls into one of four classes according to those two bits. When a victim is requested, the block returns a way from the lowest class that holds at least one way.

The surrounding cache controller reports lookups and fills. A lookup gives the way that hit and says whether it was a write. A fill gives the way being loaded and says whether a write caused it. A periodic aging pulse wipes both flags in every way, so the ranking only reflects recent activity. Tag storage, data storage and the writeback of modified lines are outside this block.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset every referenced and modified flag is 0, `vic_valid` is low, and the first victim requested is way 0.
- R2: An access (`acc_en`) sets the referenced flag of way `acc_way`. If `acc_wr` is also 1, it sets that way's modified flag as well. It never clears a flag.
- R3: A fill (`fill_en`) sets the referenced flag of way `fill_way`. It sets the modified flag only when `fill_wr` is 1, and otherwise leaves that flag unchanged.
- R4: The class of a way is the 2-bit value {referenced, modified}: 0 for {0,0}, 1 for {0,1}, 2 for {1,0}, 3 for {1,1}. The victim is always taken from the numerically lowest class that holds any way.
- R5: When several ways share that lowest class, the way with the smallest index is chosen.
- R6: An `age_clr` pulse clears the referenced and modified flags of every way that is not named by an access or fill in the same cycle.
- R7: When an access or fill names a way in the same cycle as `age_clr`, the flags it sets end up at 1. The flags it does not set are cleared.
- R8: `vic_valid` is high in exactly the cycle after each cycle with `vic_req` high, and `vic_way` carries the victim in that cycle. The victim is ranked on the flags as they stood before any access, fill or clear in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe for a hit |
| acc_way | input | WAY_W | Way that was hit |
| acc_wr | input | 1 | The access is a write |
| fill_en | input | 1 | Fill strobe |
| fill_way | input | WAY_W | Way being filled |
| fill_wr | input | 1 | The fill was caused by a write |
| vic_req | input | 1 | Victim request |
| age_clr | input | 1 | Periodic aging pulse that clears all flags |
| vic_way | output | WAY_W | Chosen victim way |
| vic_valid | output | 1 | `vic_way` is valid this cycle |

## Verification
An access or fill can land in the same cycle as the aging pulse. The bench drives both together, for reads and for writes. It then requests a victim, and the chosen way shows whether the named way kept its set flags while every other way dropped back to class 0. A victim request that coincides with an access is also checked: the result must reflect the flags from before that access, and a second request must reflect them after it.

// File: rtl/nru_pkg.sv
package nru_pkg;
   // Rank of a way, built as {referenced, modified}
   typedef enum logic [1:0] {
      RANK_COLD      = 2'd0,
      RANK_DIRTY     = 2'd1,
      RANK_TOUCHED   = 2'd2,
      RANK_HOT_DIRTY = 2'd3
   } nru_rank_e;

   localparam int unsigned RANK_LEVELS = 4;
endpackage

// File: rtl/nru_flag_bank.sv
module nru_flag_bank #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic [WAY_W-1:0] acc_way,
   input  logic             acc_wr,
   input  logic             fill_en,
   input  logic [WAY_W-1:0] fill_way,
   input  logic             fill_wr,
   input  logic             age_clr,
   output logic [WAYS-1:0]  ref_q,
   output logic [WAYS-1:0]  mod_q
);
   for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic acc_hit, fill_hit, set_ref, set_mod;
      assign acc_hit  = acc_en  && (acc_way  == WAY_W'(g));
      assign fill_hit = fill_en && (fill_way == WAY_W'(g));
      assign set_ref  = acc_hit || fill_hit;
      assign set_mod  = (acc_hit && acc_wr) || (fill_hit && fill_wr);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ref_q[g] <= 1'b0;
            mod_q[g] <= 1'b0;
         end else begin
            // setting beats the aging clear
            ref_q[g] <= set_ref | (ref_q[g] & ~age_clr);
            mod_q[g] <= set_mod | (mod_q[g] & ~age_clr);
         end
      end

      // R2
      acc_sets_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_en && acc_way == WAY_W'(g)) |=> ref_q[g]);
      // R2
      wr_sets_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_en && acc_wr && acc_way == WAY_W'(g)) |=> mod_q[g]);
      // R3
      fill_rd_keeps_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fill_en && !fill_wr && fill_way == WAY_W'(g) && !age_clr &&
          !(acc_en && acc_way == WAY_W'(g))) |=> $stable(mod_q[g]));
      // R6
      age_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (age_clr && !(acc_en && acc_way == WAY_W'(g)) &&
          !(fill_en && fill_way == WAY_W'(g))) |=> (!ref_q[g] && !mod_q[g]));
      // R7
      set_beats_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (age_clr && fill_en && fill_way == WAY_W'(g)) |=> ref_q[g]);
   end
endmodule

// File: rtl/nru_rank_map.sv
module nru_rank_map
   import nru_pkg::*;
#(
   parameter int unsigned WAYS = 4
) (
   input  logic [WAYS-1:0]                  ref_i,
   input  logic [WAYS-1:0]                  mod_i,
   output nru_rank_e [WAYS-1:0]             rank_o,
   output logic [RANK_LEVELS-1:0][WAYS-1:0] member_o
);
   for (genvar g = 0; g < WAYS; g++) begin : g_rank
      assign rank_o[g] = nru_rank_e'({ref_i[g], mod_i[g]});
      for (genvar c = 0; c < RANK_LEVELS; c++) begin : g_lvl
         assign member_o[c][g] = (rank_o[g] == nru_rank_e'(c));
      end
   end
endmodule

// File: rtl/nru_pick_low.sv
module nru_pick_low
   import nru_pkg::*;
#(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [RANK_LEVELS-1:0][WAYS-1:0] member_i,
   output logic [WAY_W-1:0]                 pick_o
);
   logic [WAYS-1:0] low_set;
   logic            lvl_found;
   logic            way_found;

   always_comb begin
      low_set   = member_i[RANK_LEVELS-1];
      lvl_found = 1'b0;
      for (int c = 0; c < RANK_LEVELS; c++) begin
         if (!lvl_found && (|member_i[c])) begin
            low_set   = member_i[c];
            lvl_found = 1'b1;
         end
      end
      pick_o    = '0;
      way_found = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         if (!way_found && low_set[i]) begin
            pick_o    = WAY_W'(i);
            way_found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
   import nru_pkg::*;
#(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic [WAY_W-1:0] acc_way,
   input  logic             acc_wr,
   input  logic             fill_en,
   input  logic [WAY_W-1:0] fill_way,
   input  logic             fill_wr,
   input  logic             vic_req,
   input  logic             age_clr,
   output logic [WAY_W-1:0] vic_way,
   output logic             vic_valid
);
   if (WAYS < 2) begin : g_bad_ways
      $error("nru_victim_sel: WAYS must be at least 2");
   end
   if (WAY_W != $clog2(WAYS)) begin : g_bad_width
      $error("nru_victim_sel: WAY_W must equal clog2(WAYS)");
   end

   logic [WAYS-1:0]                  ref_w, mod_w;
   nru_rank_e [WAYS-1:0]             rank_w;
   logic [RANK_LEVELS-1:0][WAYS-1:0] member_w;
   logic [WAY_W-1:0]                 pick_w;

   nru_flag_bank #(.WAYS(WAYS), .WAY_W(WAY_W)) i_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_en   (acc_en),
      .acc_way  (acc_way),
      .acc_wr   (acc_wr),
      .fill_en  (fill_en),
      .fill_way (fill_way),
      .fill_wr  (fill_wr),
      .age_clr  (age_clr),
      .ref_q    (ref_w),
      .mod_q    (mod_w)
   );

   nru_rank_map #(.WAYS(WAYS)) i_rank (
      .ref_i    (ref_w),
      .mod_i    (mod_w),
      .rank_o   (rank_w),
      .member_o (member_w)
   );

   nru_pick_low #(.WAYS(WAYS), .WAY_W(WAY_W)) i_pick (
      .member_i (member_w),
      .pick_o   (pick_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vic_way   <= '0;
         vic_valid <= 1'b0;
      end else begin
         vic_valid <= vic_req;
         if (vic_req) vic_way <= pick_w;
      end
   end

   // R8
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_req |=> vic_valid);
   // R8
   no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_req |=> !vic_valid);

   for (genvar g = 0; g < WAYS; g++) begin : g_order
      // R4
      lowest_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rank_w[pick_w] <= rank_w[g]);
      // R5
      lowest_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rank_w[pick_w] == rank_w[g]) |-> (pick_w <= WAY_W'(g)));
   end
endmodule

// File: tb/test_nru_victim_sel.sv
module test_nru_victim_sel;
   localparam int unsigned WAYS  = 4;
   localparam int unsigned WAY_W = 2;
   localparam int unsigned NVEC  = 13;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_en = 1'b0, acc_wr = 1'b0;
   logic [WAY_W-1:0] acc_way = '0;
   logic             fill_en = 1'b0, fill_wr = 1'b0;
   logic [WAY_W-1:0] fill_way = '0;
   logic             vic_req = 1'b0, age_clr = 1'b0;
   logic [WAY_W-1:0] vic_way;
   logic             vic_valid;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   nru_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) i_nru_victim_sel (
      .clk(clk), .rst_n(rst_n),
      .acc_en(acc_en), .acc_way(acc_way), .acc_wr(acc_wr),
      .fill_en(fill_en), .fill_way(fill_way), .fill_wr(fill_wr),
      .vic_req(vic_req), .age_clr(age_clr),
      .vic_way(vic_way), .vic_valid(vic_valid)
   );

   // {acc_en, acc_way, acc_wr, fill_en, fill_way, fill_wr, age_clr, expected victim}
   localparam logic [10:0] VEC [NVEC] = '{
      {1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0}, // R1 R5 all cold
      {1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1}, // R2 read touches 0
      {1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2}, // R2 write on 1
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 2'd3}, // R3 write fill on 2
      {1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0}, // R3 R4 read fill; rank 2 beats 3
      {1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0}, // R6 aging wipes all
      {1'b1, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0}, // R7 write plus aging
      {1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd3}, // R2 R3 access and fill together
      {1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0}, // R4 R5 three ways at rank 2
      {1'b1, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1}, // R4 way 0 now rank 3
      {1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0}, // R7 R6 write survives aging
      {1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1}, // R7 read plus aging drops mod
      {1'b1, 2'd3, 1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 2'd1}  // R3 R2 same way hit and write fill
   };

   task automatic check(input string req, input logic [WAY_W:0] act, input logic [WAY_W:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got valid/way %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      acc_en = 1'b0; acc_wr = 1'b0; acc_way = '0;
      fill_en = 1'b0; fill_wr = 1'b0; fill_way = '0;
      age_clr = 1'b0; vic_req = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", {vic_valid, vic_way}, {1'b0, 2'd0});
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {vic_valid, vic_way}, {1'b0, 2'd0});

      for (int k = 0; k < NVEC; k++) begin
         {acc_en, acc_way, acc_wr, fill_en, fill_way, fill_wr, age_clr} = VEC[k][10:2];
         @(negedge clk);
         idle_inputs();
         vic_req = 1'b1;
         @(negedge clk);
         vic_req = 1'b0;
         check("R4/table", {vic_valid, vic_way}, {1'b1, VEC[k][1:0]});
      end

      // R8 no request, no valid
      @(negedge clk);
      check("R8", {vic_valid, vic_way}, {1'b0, 2'd1});

      // R8 request with an access in the same cycle ranks old flags
      acc_en = 1'b1; acc_way = 2'd1; acc_wr = 1'b1; vic_req = 1'b1;
      @(negedge clk);
      idle_inputs();
      vic_req = 1'b1;
      check("R8", {vic_valid, vic_way}, {1'b1, 2'd1});
      @(negedge clk);
      vic_req = 1'b0;
      // R8 back-to-back: now way 1 is rank 3, way 2 rank 0
      check("R8", {vic_valid, vic_way}, {1'b1, 2'd2});
      @(negedge clk);
      check("R8", vic_valid, 1'b0);

      // R6 R1 aging after everything goes back to way 0
      age_clr = 1'b1;
      @(negedge clk);
      idle_inputs();
      vic_req = 1'b1;
      @(negedge clk);
      vic_req = 1'b0;
      check("R6", {vic_valid, vic_way}, {1'b1, 2'd0});

      // R1 reset mid-run clears flags
      acc_en = 1'b1; acc_way = 2'd0;
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", vic_valid, 1'b0);
      rst_n = 1'b1;
      vic_req = 1'b1;
      @(negedge clk);
      vic_req = 1'b0;
      check("R1", {vic_valid, vic_way}, {1'b1, 2'd0});

      finish_run();
   end
endmodule